// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block is the home-node directory for a small set of cache lines in a three-state (Modified, Shared, Invalid) coherence scheme. It keeps an exact record for every line: a stable state (I, S, M) or the transient state S-D, a bit vector of sharing caches, and the identity of the owning cache. Requests from caches arrive on one channel and are served one per cycle. Data write-backs arrive on a second channel, and the line contents live in a small memory inside the block. The directory answers on two output channels: data replies carrying an invalidation-ack count, and forwarded messages (forwarded read, forwarded write, invalidate, put acknowledge).

Messages on different channels may overtake each other, so a cache can send an eviction after the directory has already moved ownership away from it. The directory therefore acknowledges every eviction request, whatever the line's state. It applies an eviction's side effects only when the sender still holds the role the request claims. When a read hits a modified line, the line waits in S-D for the old owner's write-back. During that wait, reads and writes to the line are held back, but evictions still proceed.

Top module: `msiDirectory`

## Requirements
- R1: After reset every line is in state I with no sharers, line n of the memory holds INIT_BASE+n, reqReady is high and neither output channel is valid.
- R2: Request codes are 0 read (GetS), 1 write (GetM), 2 clean eviction (PutS), 3 dirty eviction with data (PutM). A read to a line in I or S returns the line's memory data with ack count 0, adds the requester to the sharers and leaves the line in S.
- R3: A write to a line in I returns data with ack count 0, makes the requester the owner and moves the line to M.
- R4: A write to a line in S returns data whose ack count equals the number of sharers other than the requester. The directory then sends one invalidate per cycle to each of those sharers in ascending id order, each carrying the requester id, and none to the requester. It clears the sharers, makes the requester the owner, moves to M, and holds reqReady low until the last invalidate has left.
- R5: Forwarded codes are 0 forwarded read, 1 forwarded write, 2 invalidate, 3 put acknowledge. A read to a line in M sends a forwarded read to the owner carrying the requester id, makes the requester and the old owner the sharers, and moves the line to S-D with no data reply.
- R6: While a line is in S-D, reads and writes to it are stalled (reqReady low), while clean and dirty evictions to it are accepted.
- R7: A write-back to a line in S-D stores its data in memory and moves the line to S. A write-back to a line in any other state changes nothing.
- R8: A write to a line in M sends a forwarded write to the current owner carrying the requester id, makes the requester the owner, and leaves the line in M without a data reply.
- R9: A clean eviction always gets a put acknowledge to the sender. In S or S-D it removes the sender from the sharers, and a line in S whose sharer set becomes empty moves to I.
- R10: A dirty eviction from the owner of a line in M writes its data to memory, gets a put acknowledge and moves the line to I.
- R11: A dirty eviction from any non-owner gets only a put acknowledge. Its data is discarded, and in S or S-D it removes the sender from the sharers (a line in S left with no sharers moves to I).
- R12: A cycle with a valid write-back accepts no request (reqReady low). Every reply appears on its channel for exactly one cycle, in the cycle after the request or the last-but-one invalidate was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at this edge when valid |
| reqType | input | 2 | Request code |
| reqSrc | input | ID_W | Requesting cache id |
| reqLine | input | LINE_W | Line index |
| reqData | input | DATA_W | Data carried by a dirty eviction |
| wbValid | input | 1 | Owner write-back present |
| wbLine | input | LINE_W | Write-back line index |
| wbData | input | DATA_W | Write-back data |
| rspValid | output | 1 | Data reply valid |
| rspDst | output | ID_W | Data reply destination |
| rspLine | output | LINE_W | Data reply line |
| rspData | output | DATA_W | Line data |
| rspAcks | output | ID_W | Invalidate acks to expect |
| fwdValid | output | 1 | Forwarded message valid |
| fwdType | output | 2 | Forwarded message code |
| fwdDst | output | ID_W | Destination cache |
| fwdLine | output | LINE_W | Line index |
| fwdReq | output | ID_W | Original requester id |

## Verification
On every cycle the assertions check several port-level rules. A data reply must follow an accepted read or write, and a read's reply carries no acks. A put acknowledge must go back to the sender of an accepted eviction. An invalidate is never addressed to its own requester. A write-back cycle takes no request, and a reply with a non-zero ack count finds the request channel closed. The effects that depend on line history can only be shown by the bench's scenarios: sharer removal seen through later ack counts, ownership seen through the destination of later forwards, stale evictions that must leave memory untouched, and the S-D stall lifted by the write-back.

// File: rtl/msiDirPkg.sv
package msiDirPkg;

  typedef enum logic [1:0] {
    REQ_GETS = 2'd0,
    REQ_GETM = 2'd1,
    REQ_PUTS = 2'd2,
    REQ_PUTM = 2'd3
  } reqKind_t;

  typedef enum logic [1:0] {
    FWD_GETS   = 2'd0,
    FWD_GETM   = 2'd1,
    FWD_INV    = 2'd2,
    FWD_PUTACK = 2'd3
  } fwdKind_t;

  typedef enum logic [1:0] {
    LN_I  = 2'd0,
    LN_S  = 2'd1,
    LN_M  = 2'd2,
    LN_SD = 2'd3
  } lineState_t;

  // strobes from control to datapath for the request taken this cycle
  typedef struct packed {
    logic     accept;
    logic     addReq;
    logic     addOwner;
    logic     removeReq;
    logic     clearSharers;
    logic     setOwner;
    logic     memFromReq;
    logic     memFromWb;
    logic     sendData;
    logic     sendFwd;
    fwdKind_t fwdKind;
    logic     startInv;
  } dirStrobes_t;

endpackage

// File: rtl/msiDirCtrl.sv
module msiDirCtrl
  import msiDirPkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_LINES  = 4,
  parameter int ID_W       = 2,
  parameter int LINE_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqType,
  input  logic [ID_W-1:0]       reqSrc,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic                  wbValid,
  input  logic [LINE_W-1:0]     wbLine,
  input  logic [NUM_CACHES-1:0] lineSharers,
  input  logic [ID_W-1:0]       lineOwner,
  input  logic                  invBusy,
  output logic                  reqReady,
  output dirStrobes_t           strobe
);

  lineState_t stateVec [NUM_LINES];
  lineState_t curState;
  lineState_t nextState;
  reqKind_t   kind;
  logic       isGet;
  logic       accept;
  logic       wbHit;
  logic [NUM_CACHES-1:0] reqBit;
  logic       lastLeave;

  assign kind      = reqKind_t'(reqType);
  assign curState  = stateVec[reqLine];
  assign isGet     = (kind == REQ_GETS) || (kind == REQ_GETM);
  assign reqReady  = !wbValid && !invBusy && !(isGet && curState == LN_SD);
  assign accept    = reqValid && reqReady;
  assign wbHit     = wbValid && (stateVec[wbLine] == LN_SD);
  assign reqBit    = NUM_CACHES'(1) << reqSrc;
  assign lastLeave = ((lineSharers & ~reqBit) == '0);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    lineState_t st;
    always_ff @(posedge clk) begin
      if (!rstN)
        st <= LN_I;
      else if (wbHit && wbLine == LINE_W'(g))
        st <= LN_S;
      else if (accept && reqLine == LINE_W'(g))
        st <= nextState;
    end
    assign stateVec[g] = st;
  end

  always_comb begin
    strobe           = '0;
    strobe.accept    = accept;
    strobe.memFromWb = wbHit;
    nextState        = curState;
    if (accept) begin
      unique case (kind)
        REQ_GETS: begin
          if (curState == LN_M) begin
            strobe.sendFwd      = 1'b1;
            strobe.fwdKind      = FWD_GETS;
            strobe.clearSharers = 1'b1;
            strobe.addReq       = 1'b1;
            strobe.addOwner     = 1'b1;
            nextState           = LN_SD;
          end else begin
            strobe.sendData = 1'b1;
            strobe.addReq   = 1'b1;
            nextState       = LN_S;
          end
        end
        REQ_GETM: begin
          strobe.setOwner = 1'b1;
          nextState       = LN_M;
          if (curState == LN_M) begin
            strobe.sendFwd = 1'b1;
            strobe.fwdKind = FWD_GETM;
          end else begin
            strobe.sendData = 1'b1;
            if (curState == LN_S) begin
              strobe.startInv     = 1'b1;
              strobe.clearSharers = 1'b1;
            end
          end
        end
        REQ_PUTS: begin
          strobe.sendFwd = 1'b1;
          strobe.fwdKind = FWD_PUTACK;
          if (curState == LN_S || curState == LN_SD)
            strobe.removeReq = 1'b1;
          if (curState == LN_S && lastLeave)
            nextState = LN_I;
        end
        default: begin
          strobe.sendFwd = 1'b1;
          strobe.fwdKind = FWD_PUTACK;
          if (curState == LN_M && lineOwner == reqSrc) begin
            strobe.memFromReq = 1'b1;
            nextState         = LN_I;
          end else if (curState == LN_S || curState == LN_SD) begin
            strobe.removeReq = 1'b1;
            if (curState == LN_S && lastLeave)
              nextState = LN_I;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/msiDirData.sv
module msiDirData
  import msiDirPkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_LINES  = 4,
  parameter int DATA_W     = 16,
  parameter int INIT_BASE  = 'hA000,
  parameter int ID_W       = 2,
  parameter int LINE_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dirStrobes_t           strobe,
  input  logic [ID_W-1:0]       reqSrc,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic [DATA_W-1:0]     reqData,
  input  logic [LINE_W-1:0]     wbLine,
  input  logic [DATA_W-1:0]     wbData,
  output logic [NUM_CACHES-1:0] lineSharers,
  output logic [ID_W-1:0]       lineOwner,
  output logic                  invBusy,
  output logic                  rspValid,
  output logic [ID_W-1:0]       rspDst,
  output logic [LINE_W-1:0]     rspLine,
  output logic [DATA_W-1:0]     rspData,
  output logic [ID_W-1:0]       rspAcks,
  output logic                  fwdValid,
  output logic [1:0]            fwdType,
  output logic [ID_W-1:0]       fwdDst,
  output logic [LINE_W-1:0]     fwdLine,
  output logic [ID_W-1:0]       fwdReq
);

  logic [NUM_CACHES-1:0] sharers [NUM_LINES];
  logic [ID_W-1:0]       owner   [NUM_LINES];
  logic [DATA_W-1:0]     mem     [NUM_LINES];

  logic [NUM_CACHES-1:0] reqBit;
  logic [NUM_CACHES-1:0] otherSharers;
  logic [NUM_CACHES-1:0] nextSharers;
  logic [ID_W-1:0]       otherCount;

  logic [NUM_CACHES-1:0] invMask;
  logic [ID_W-1:0]       invReq;
  logic [LINE_W-1:0]     invLine;
  logic [ID_W-1:0]       invPick;

  assign reqBit       = NUM_CACHES'(1) << reqSrc;
  assign lineSharers  = sharers[reqLine];
  assign lineOwner    = owner[reqLine];
  assign otherSharers = lineSharers & ~reqBit;
  assign invBusy      = (invMask != '0);

  always_comb begin
    otherCount = '0;
    for (int i = 0; i < NUM_CACHES; i++)
      otherCount = otherCount + ID_W'(otherSharers[i]);
  end

  always_comb begin
    invPick = '0;
    for (int i = NUM_CACHES - 1; i >= 0; i--)
      if (invMask[i]) invPick = ID_W'(i);
  end

  always_comb begin
    nextSharers = lineSharers;
    if (strobe.clearSharers) nextSharers = '0;
    if (strobe.addOwner)     nextSharers = nextSharers | (NUM_CACHES'(1) << lineOwner);
    if (strobe.removeReq)    nextSharers = nextSharers & ~reqBit;
    if (strobe.addReq)       nextSharers = nextSharers | reqBit;
  end

  // line records and memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        sharers[i] <= '0;
        owner[i]   <= '0;
        mem[i]     <= DATA_W'(INIT_BASE + i);
      end
    end else begin
      if (strobe.accept) begin
        sharers[reqLine] <= nextSharers;
        if (strobe.setOwner) owner[reqLine] <= reqSrc;
      end
      if (strobe.memFromReq) mem[reqLine] <= reqData;
      if (strobe.memFromWb)  mem[wbLine]  <= wbData;
    end
  end

  // invalidate drain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      invMask <= '0;
      invReq  <= '0;
      invLine <= '0;
    end else if (strobe.startInv) begin
      invMask <= otherSharers;
      invReq  <= reqSrc;
      invLine <= reqLine;
    end else if (invBusy) begin
      invMask <= invMask & ~(NUM_CACHES'(1) << invPick);
    end
  end

  // data reply channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspDst   <= '0;
      rspLine  <= '0;
      rspData  <= '0;
      rspAcks  <= '0;
    end else begin
      rspValid <= strobe.sendData;
      if (strobe.sendData) begin
        rspDst  <= reqSrc;
        rspLine <= reqLine;
        rspData <= mem[reqLine];
        rspAcks <= strobe.startInv ? otherCount : '0;
      end
    end
  end

  // forwarded channel
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdType  <= '0;
      fwdDst   <= '0;
      fwdLine  <= '0;
      fwdReq   <= '0;
    end else if (strobe.sendFwd) begin
      fwdValid <= 1'b1;
      fwdType  <= strobe.fwdKind;
      fwdDst   <= (strobe.fwdKind == FWD_PUTACK) ? reqSrc : lineOwner;
      fwdLine  <= reqLine;
      fwdReq   <= reqSrc;
    end else if (invBusy) begin
      fwdValid <= 1'b1;
      fwdType  <= FWD_INV;
      fwdDst   <= invPick;
      fwdLine  <= invLine;
      fwdReq   <= invReq;
    end else begin
      fwdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/msiDirectory.sv
module msiDirectory
  import msiDirPkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_LINES  = 4,
  parameter int DATA_W     = 16,
  parameter int INIT_BASE  = 'hA000,
  parameter int ID_W       = $clog2(NUM_CACHES),
  parameter int LINE_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqType,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [DATA_W-1:0] reqData,
  input  logic              wbValid,
  input  logic [LINE_W-1:0] wbLine,
  input  logic [DATA_W-1:0] wbData,
  output logic              rspValid,
  output logic [ID_W-1:0]   rspDst,
  output logic [LINE_W-1:0] rspLine,
  output logic [DATA_W-1:0] rspData,
  output logic [ID_W-1:0]   rspAcks,
  output logic              fwdValid,
  output logic [1:0]        fwdType,
  output logic [ID_W-1:0]   fwdDst,
  output logic [LINE_W-1:0] fwdLine,
  output logic [ID_W-1:0]   fwdReq
);

  dirStrobes_t           strobe;
  logic [NUM_CACHES-1:0] lineSharers;
  logic [ID_W-1:0]       lineOwner;
  logic                  invBusy;

  msiDirCtrl #(
    .NUM_CACHES(NUM_CACHES), .NUM_LINES(NUM_LINES),
    .ID_W(ID_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqType(reqType), .reqSrc(reqSrc), .reqLine(reqLine),
    .wbValid(wbValid), .wbLine(wbLine),
    .lineSharers(lineSharers), .lineOwner(lineOwner), .invBusy(invBusy),
    .reqReady(reqReady), .strobe(strobe)
  );

  msiDirData #(
    .NUM_CACHES(NUM_CACHES), .NUM_LINES(NUM_LINES), .DATA_W(DATA_W),
    .INIT_BASE(INIT_BASE), .ID_W(ID_W), .LINE_W(LINE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqSrc(reqSrc), .reqLine(reqLine), .reqData(reqData),
    .wbLine(wbLine), .wbData(wbData),
    .lineSharers(lineSharers), .lineOwner(lineOwner), .invBusy(invBusy),
    .rspValid(rspValid), .rspDst(rspDst), .rspLine(rspLine),
    .rspData(rspData), .rspAcks(rspAcks),
    .fwdValid(fwdValid), .fwdType(fwdType), .fwdDst(fwdDst),
    .fwdLine(fwdLine), .fwdReq(fwdReq)
  );

endmodule

// File: rtl/msiDirChecker.sv
module msiDirChecker #(
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [1:0]      reqType,
  input logic [ID_W-1:0] reqSrc,
  input logic            wbValid,
  input logic            rspValid,
  input logic [ID_W-1:0] rspAcks,
  input logic            fwdValid,
  input logic [1:0]      fwdType,
  input logic [ID_W-1:0] fwdDst,
  input logic [ID_W-1:0] fwdReq
);

  // R12
  wb_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !reqReady);

  // R2
  rsp_follows_get_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && !reqType[1]));

  // R2
  gets_no_acks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqType) == 2'd0) |-> rspAcks == '0);

  // R4
  inv_pending_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAcks != '0) |-> !reqReady);

  // R4
  inv_not_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdType == 2'd2) |-> fwdDst != fwdReq);

  // R9
  putack_to_sender_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdType == 2'd3) |->
      ($past(reqValid && reqReady && reqType[1]) && fwdDst == $past(reqSrc)));

endmodule

bind msiDirectory msiDirChecker #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqType(reqType), .reqSrc(reqSrc), .wbValid(wbValid),
  .rspValid(rspValid), .rspAcks(rspAcks),
  .fwdValid(fwdValid), .fwdType(fwdType), .fwdDst(fwdDst), .fwdReq(fwdReq)
);

// File: tb/test_msiDirectory.sv
module test_msiDirectory;

  localparam int NC = 4;
  localparam int NL = 4;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int LW = 2;
  localparam int BASE = 'hA000;

  localparam logic [1:0] GS = 2'd0, GM = 2'd1, PS = 2'd2, PM = 2'd3;
  localparam logic [1:0] F_GS = 2'd0, F_GM = 2'd1, F_INV = 2'd2, F_ACK = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqType = '0;
  logic [IW-1:0] reqSrc = '0;
  logic [LW-1:0] reqLine = '0;
  logic [DW-1:0] reqData = '0;
  logic wbValid = 1'b0;
  logic [LW-1:0] wbLine = '0;
  logic [DW-1:0] wbData = '0;
  logic rspValid;
  logic [IW-1:0] rspDst, rspAcks;
  logic [LW-1:0] rspLine;
  logic [DW-1:0] rspData;
  logic fwdValid;
  logic [1:0] fwdType;
  logic [IW-1:0] fwdDst, fwdReq;
  logic [LW-1:0] fwdLine;

  always #2 clk = ~clk;

  msiDirectory #(.NUM_CACHES(NC), .NUM_LINES(NL), .DATA_W(DW), .INIT_BASE(BASE)) i_msiDirectory (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqType(reqType), .reqSrc(reqSrc), .reqLine(reqLine), .reqData(reqData),
    .wbValid(wbValid), .wbLine(wbLine), .wbData(wbData),
    .rspValid(rspValid), .rspDst(rspDst), .rspLine(rspLine), .rspData(rspData),
    .rspAcks(rspAcks), .fwdValid(fwdValid), .fwdType(fwdType), .fwdDst(fwdDst),
    .fwdLine(fwdLine), .fwdReq(fwdReq)
  );

  int tests = 0, fails = 0;
  int rspN = 0, rspRd = 0, fwdN = 0, fwdRd = 0;
  int rspLog [64];
  int fwdLog [64];

  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid && rspN < 64) begin
        rspLog[rspN] = {rspDst, rspLine, rspData, rspAcks};
        rspN++;
      end
      if (fwdValid && fwdN < 64) begin
        fwdLog[fwdN] = {fwdType, fwdDst, fwdLine, fwdReq};
        fwdN++;
      end
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendReq(input logic [1:0] t, input int src, input int line, input int data);
    @(negedge clk);
    reqValid = 1'b1; reqType = t; reqSrc = IW'(src); reqLine = LW'(line); reqData = DW'(data);
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic driveWb(input int line, input int data, input string tag);
    @(negedge clk);
    wbValid = 1'b1; wbLine = LW'(line); wbData = DW'(data);
    #1;
    checkEq(tag, int'(reqReady), 0);
    @(negedge clk);
    wbValid = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input int dst, input int line, input int data, input int acks);
    if (rspRd >= rspN) checkEq({tag, " missing reply"}, rspN, rspRd + 1);
    else begin
      checkEq(tag, rspLog[rspRd], {IW'(dst), LW'(line), DW'(data), IW'(acks)});
      rspRd++;
    end
  endtask

  task automatic expectFwd(input string tag, input logic [1:0] t, input int dst, input int line, input int rq);
    if (fwdRd >= fwdN) checkEq({tag, " missing forward"}, fwdN, fwdRd + 1);
    else begin
      checkEq(tag, fwdLog[fwdRd], {t, IW'(dst), LW'(line), IW'(rq)});
      fwdRd++;
    end
  endtask

  task automatic expectQuiet(input string tag);
    checkEq(tag, (rspN - rspRd) + (fwdN - fwdRd), 0);
    rspRd = rspN;
    fwdRd = fwdN;
  endtask

  task automatic finishRun;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int prev;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    checkEq("R1 reqReady", int'(reqReady), 1);
    checkEq("R1 outputs idle", rspN + fwdN, 0);

    // R2 four readers on line 0
    for (int c = 0; c < NC; c++) begin
      sendReq(GS, c, 0, 0); idle(1);
      expectRsp("R2 read in I/S", c, 0, BASE, 0);
    end
    // R4 upgrade by cache 2
    sendReq(GM, 2, 0, 0);
    checkEq("R4 stalled during invalidates", int'(reqReady), 0);
    idle(6);
    expectRsp("R4 ack count", 2, 0, BASE, 3);
    expectFwd("R4 inv 0", F_INV, 0, 0, 2);
    expectFwd("R4 inv 1", F_INV, 1, 0, 2);
    expectFwd("R4 inv 3", F_INV, 3, 0, 2);
    expectQuiet("R4 no extra");

    // R8 write in M
    sendReq(GM, 1, 0, 0); idle(1);
    expectFwd("R8 fwd write", F_GM, 2, 0, 1);
    expectQuiet("R8 no data reply");
    // R5 read in M
    sendReq(GS, 3, 0, 0); idle(1);
    expectFwd("R5 fwd read", F_GS, 1, 0, 3);
    expectQuiet("R5 no data reply");

    // R6/R9 evictions served in S-D
    sendReq(PS, 3, 0, 0); idle(1);
    expectFwd("R9 puts ack in S-D", F_ACK, 3, 0, 3);
    sendReq(PM, 0, 0, 'hBEEF); idle(1);
    expectFwd("R11 stale putm ack", F_ACK, 0, 0, 0);
    expectQuiet("R6 evictions only ack");
    // R6 stall until write-back, R7 data stored
    fork
      sendReq(GS, 0, 0, 0);
      begin
        idle(3);
        checkEq("R6 read stalled in S-D", int'(reqReady), 0);
        checkEq("R6 no reply while stalled", rspN - rspRd, 0);
        driveWb(0, 'h1234, "R12 wb blocks request");
      end
    join
    idle(1);
    expectRsp("R7 data from write-back", 0, 0, 'h1234, 0);
    // sharers are {0,1}: 3 left, 0 joined
    sendReq(GM, 1, 0, 0); idle(4);
    expectRsp("R9 removal seen in ack count", 1, 0, 'h1234, 1);
    expectFwd("R4 single inv", F_INV, 0, 0, 1);
    expectQuiet("R9 no extra");

    // R10 owner eviction
    sendReq(PM, 1, 0, 'h5555); idle(1);
    expectFwd("R10 putm ack", F_ACK, 1, 0, 1);
    sendReq(GS, 2, 0, 0); idle(1);
    expectRsp("R10 memory written", 2, 0, 'h5555, 0);
    sendReq(PS, 2, 0, 0); idle(1);
    expectFwd("R9 last sharer ack", F_ACK, 2, 0, 2);
    sendReq(GM, 3, 0, 0); idle(4);
    expectRsp("R9 line back in I", 3, 0, 'h5555, 0);
    expectQuiet("R3 no invalidates from I");

    // R11 stale evictions in M
    sendReq(PS, 0, 0, 0); idle(1);
    expectFwd("R9 puts ack in M", F_ACK, 0, 0, 0);
    sendReq(PM, 0, 0, 'h9999); idle(1);
    expectFwd("R11 non-owner putm in M", F_ACK, 0, 0, 0);
    sendReq(GM, 2, 0, 0); idle(1);
    expectFwd("R11 owner unchanged", F_GM, 3, 0, 2);
    sendReq(PM, 3, 0, 'h1111); idle(1);
    expectFwd("R11 stale old owner ack", F_ACK, 3, 0, 3);
    sendReq(GS, 1, 0, 0); idle(1);
    expectFwd("R5 fwd read to new owner", F_GS, 2, 0, 1);
    driveWb(0, 'h2468, "R12 wb blocks request");
    sendReq(GS, 0, 0, 0); idle(1);
    expectRsp("R11 stale data discarded", 0, 0, 'h2468, 0);
    expectQuiet("R11 no extra");

    // R7 write-back to a line not in S-D is ignored
    driveWb(1, 'h7777, "R12 wb blocks request");
    sendReq(GS, 0, 1, 0); idle(1);
    expectRsp("R7 stray write-back ignored", 0, 1, BASE + 1, 0);

    // R3/R4/R10 sweep on line 2
    prev = BASE + 2;
    for (int r = 0; r < NC; r++) begin
      for (int c = 0; c <= r; c++) begin
        sendReq(GS, c, 2, 0); idle(1);
        expectRsp("R2 sweep read", c, 2, prev, 0);
      end
      sendReq(GM, r, 2, 0);
      if (r > 0) checkEq("R4 sweep stall", int'(reqReady), 0);
      idle(6);
      expectRsp("R4 sweep acks", r, 2, prev, r);
      for (int c = 0; c < r; c++) expectFwd("R4 sweep inv", F_INV, c, 2, r);
      expectQuiet("R4 sweep no extra");
      sendReq(PM, r, 2, 'hC000 + r); idle(1);
      expectFwd("R10 sweep ack", F_ACK, r, 2, r);
      prev = 'hC000 + r;
    end
    // R3 write on a line in I
    sendReq(GM, 1, 3, 0); idle(3);
    expectRsp("R3 write in I", 1, 3, BASE + 3, 0);
    expectQuiet("R3 no forwards");

    finishRun();
  end

endmodule